// File: doc/BRIEF.md
# Double-Buffered Transmit Ingress

This block is the device-side half of a transmit handshake. A host places packets into two fixed packet buffers, used in strict turn. The host writes a 16-byte descriptor and the packet body into whichever buffer is free, then pulses a doorbell. The block counts the packet in and presents the oldest filled buffer to a downstream consumer. The consumer gets the buffer index and the decoded descriptor fields through a valid/ready handshake. It reads the packet body through a word read port and pulses `pkt_done` when it no longer needs the buffer.

Flow control rests on two free-running counters, an in-count and an out-count. Their modulo-16 difference is the number of occupied buffers. The out-count is visible to the host as a 4-bit status field, so the host can tell when a buffer has come free. Host writes are steered automatically to buffer `in_count mod 2`. A doorbell that arrives while both buffers are occupied is refused and reported as an overflow pulse. The storage is a plain register array.

Top module: `txdb_ingress`

## Requirements
- R1: After reset the status out-count is 0, `pkt_valid` and `ovf_err` are low, and the first packet uses buffer 0.
- R2: A doorbell while fewer than 2 buffers are occupied advances the in-count by one. Host writes land in buffer (in-count mod 2), so successive packets alternate between buffer 0 and buffer 1.
- R3: A doorbell while 2 buffers are occupied raises `ovf_err` for exactly one cycle and does not advance the in-count.
- R4: Host writes made while both buffers are occupied are ignored and leave every stored word unchanged.
- R5: `pkt_valid` is high while at least one buffer is occupied and the head buffer has not yet been accepted. `pkt_buf` equals out-count mod 2. While `pkt_ready` is low, `pkt_valid`, `pkt_buf` and the descriptor stay stable.
- R6: `pkt_done` after the head buffer has been accepted (`pkt_valid` and `pkt_ready` at a clock edge) advances the out-count by one and frees that buffer. `pkt_done` without an accepted buffer is ignored.
- R7: Descriptor decode from the head buffer uses four 32-bit words. Word 0 holds length in bits 15:0 and rate mask in bits 31:16. Word 1 holds expiry. Word 2 holds queue in bits 7:0, id in bits 15:8 and the control word in bits 31:16. Word 3 holds fragment threshold in bits 15:0 and block count in bits 23:16. Control bits are: policy in 2:0, no-ack in 3, type in 5:4, QoS in 6, completion request in 7, transfer pad in 8.
- R8: `pkt_len` is the stored length rounded up to a multiple of 4, truncated to 16 bits, so 0xFFFD..0xFFFF give 0.
- R9: The status out-count is 4 bits wide and wraps from 15 to 0. Flow control stays correct across the wrap.
- R10: `rd_data` returns the word at `rd_addr` of the head buffer, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Host word write strobe |
| hw_addr | input | 4 | Host word address within the free buffer |
| hw_data | input | 32 | Host write data |
| db | input | 1 | Host doorbell pulse |
| stat_out_cnt | output | 4 | Out-count status field |
| ovf_err | output | 1 | One-cycle pulse on a refused doorbell |
| pkt_valid | output | 1 | Head buffer offered to consumer |
| pkt_ready | input | 1 | Consumer accepts the offer |
| pkt_buf | output | 1 | Index of the head buffer |
| pkt_len | output | 16 | Rounded packet length |
| pkt_rate | output | 16 | Initial rate mask |
| pkt_expiry | output | 32 | Expiry time in microseconds |
| pkt_queue | output | 8 | Queue index |
| pkt_id | output | 8 | Packet id |
| pkt_policy | output | 3 | Rate policy index |
| pkt_noack | output | 1 | No-acknowledge flag |
| pkt_type | output | 2 | Packet type |
| pkt_qos | output | 1 | QoS frame flag |
| pkt_cmpl | output | 1 | Completion report request |
| pkt_pad | output | 1 | Two-byte transfer pad |
| pkt_frag | output | 16 | Fragment threshold |
| pkt_blocks | output | 8 | Memory block count |
| rd_addr | input | 4 | Consumer word read address |
| rd_data | output | 32 | Head buffer word at `rd_addr` |
| pkt_done | input | 1 | Consumer releases the accepted buffer |

## Verification
The hardest state to reach is a full pair of buffers combined with a further doorbell and a host write. In that state the write address points at the very buffer the consumer is still reading. The bench fills both buffers and holds `pkt_ready` low, then rings a third doorbell and writes over word 0. It checks through the read port that the head descriptor is untouched. It then drains both buffers, and the offer drops after exactly two releases, which proves the refused doorbell never counted. Wrap of the 4-bit out-count is reached by streaming eighteen further packets through the handshake.

// File: rtl/txdb_pkg.sv
package txdb_pkg;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] rate;
    logic [31:0] expiry;
    logic [7:0]  queue;
    logic [7:0]  id;
    logic [2:0]  policy;
    logic        noack;
    logic [1:0]  ptype;
    logic        qos;
    logic        cmpl;
    logic        pad;
    logic [15:0] frag;
    logic [7:0]  blocks;
  } txdb_desc_t;

  // round a byte length up to the next multiple of four (16-bit wrap)
  function automatic logic [15:0] txdb_round4(input logic [15:0] l);
    return (l + 16'd3) & 16'hFFFC;
  endfunction

  function automatic txdb_desc_t txdb_decode(input logic [31:0] w0, input logic [31:0] w1,
                                             input logic [31:0] w2, input logic [31:0] w3);
    txdb_desc_t d;
    d.len    = txdb_round4(w0[15:0]);
    d.rate   = w0[31:16];
    d.expiry = w1;
    d.queue  = w2[7:0];
    d.id     = w2[15:8];
    d.policy = w2[18:16];
    d.noack  = w2[19];
    d.ptype  = w2[21:20];
    d.qos    = w2[22];
    d.cmpl   = w2[23];
    d.pad    = w2[24];
    d.frag   = w3[15:0];
    d.blocks = w3[23:16];
    return d;
  endfunction

endpackage

// File: rtl/txdb_counts.sv
module txdb_counts #(
  parameter int CNT_W = 4,
  parameter int NBUF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db,
  input  logic             release_ev,
  output logic [CNT_W-1:0] in_cnt,
  output logic [CNT_W-1:0] out_cnt,
  output logic             occ_nz,
  output logic             full,
  output logic             push_ev,
  output logic             ovf_ev
);

  function automatic logic [CNT_W-1:0] occupancy(input logic [CNT_W-1:0] i, input logic [CNT_W-1:0] o);
    return i - o;
  endfunction

  logic [CNT_W-1:0] occ;

  assign occ     = occupancy(in_cnt, out_cnt);
  assign occ_nz  = (occ != '0);
  assign full    = (int'(occ) >= NBUF);
  assign push_ev = db & ~full;
  assign ovf_ev  = db & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (push_ev)    in_cnt  <= in_cnt + 1'b1;
      if (release_ev) out_cnt <= out_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/txdb_store.sv
module txdb_store #(
  parameter int NBUF  = 2,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int BUF_W  = $clog2(NBUF),
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUF_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [BUF_W-1:0]  rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [4*DW-1:0]   hdr
);

  logic [NBUF-1:0][DW-1:0]   rd_bus;
  logic [NBUF-1:0][4*DW-1:0] hdr_bus;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en && (wr_sel == BUF_W'(b))) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign rd_bus[b]  = mem[rd_addr];
    assign hdr_bus[b] = {mem[3], mem[2], mem[1], mem[0]};
  end

  assign rd_data = rd_bus[rd_sel];
  assign hdr     = hdr_bus[rd_sel];

endmodule

// File: rtl/txdb_handoff.sv
module txdb_handoff (
  input  logic clk,
  input  logic rst_n,
  input  logic occ_nz,
  input  logic ready,
  input  logic done,
  output logic valid,
  output logic taken,
  output logic accept_ev,
  output logic release_ev
);

  assign valid      = occ_nz & ~taken;
  assign accept_ev  = valid & ready;
  assign release_ev = taken & done;

  always_ff @(posedge clk) begin
    if (!rst_n)          taken <= 1'b0;
    else if (accept_ev)  taken <= 1'b1;
    else if (release_ev) taken <= 1'b0;
  end

endmodule

// File: rtl/txdb_ingress.sv
module txdb_ingress #(
  parameter int CNT_W = 4,
  parameter int NBUF  = 2,
  parameter int WORDS = 16,
  localparam int BUF_W  = $clog2(NBUF),
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [31:0]       hw_data,
  input  logic              db,
  output logic [CNT_W-1:0]  stat_out_cnt,
  output logic              ovf_err,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [BUF_W-1:0]  pkt_buf,
  output logic [15:0]       pkt_len,
  output logic [15:0]       pkt_rate,
  output logic [31:0]       pkt_expiry,
  output logic [7:0]        pkt_queue,
  output logic [7:0]        pkt_id,
  output logic [2:0]        pkt_policy,
  output logic              pkt_noack,
  output logic [1:0]        pkt_type,
  output logic              pkt_qos,
  output logic              pkt_cmpl,
  output logic              pkt_pad,
  output logic [15:0]       pkt_frag,
  output logic [7:0]        pkt_blocks,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              pkt_done
);
  import txdb_pkg::*;

  logic [CNT_W-1:0] in_cnt;
  logic [CNT_W-1:0] out_cnt;
  logic             occ_nz, full, push_ev, ovf_ev;
  logic             taken, accept_ev, release_ev;
  logic [127:0]     hdr;
  txdb_desc_t       desc;

  txdb_counts #(.CNT_W(CNT_W), .NBUF(NBUF)) u_counts (
    .clk(clk), .rst_n(rst_n), .db(db), .release_ev(release_ev),
    .in_cnt(in_cnt), .out_cnt(out_cnt), .occ_nz(occ_nz), .full(full),
    .push_ev(push_ev), .ovf_ev(ovf_ev)
  );

  txdb_store #(.NBUF(NBUF), .WORDS(WORDS), .DW(32)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(hw_en & ~full), .wr_sel(in_cnt[BUF_W-1:0]), .wr_addr(hw_addr), .wr_data(hw_data),
    .rd_sel(out_cnt[BUF_W-1:0]), .rd_addr(rd_addr), .rd_data(rd_data), .hdr(hdr)
  );

  txdb_handoff u_handoff (
    .clk(clk), .rst_n(rst_n), .occ_nz(occ_nz), .ready(pkt_ready), .done(pkt_done),
    .valid(pkt_valid), .taken(taken), .accept_ev(accept_ev), .release_ev(release_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_err <= 1'b0;
    else        ovf_err <= ovf_ev;
  end

  assign desc         = txdb_decode(hdr[31:0], hdr[63:32], hdr[95:64], hdr[127:96]);
  assign stat_out_cnt = out_cnt;
  assign pkt_buf      = out_cnt[BUF_W-1:0];
  assign pkt_len      = desc.len;
  assign pkt_rate     = desc.rate;
  assign pkt_expiry   = desc.expiry;
  assign pkt_queue    = desc.queue;
  assign pkt_id       = desc.id;
  assign pkt_policy   = desc.policy;
  assign pkt_noack    = desc.noack;
  assign pkt_type     = desc.ptype;
  assign pkt_qos      = desc.qos;
  assign pkt_cmpl     = desc.cmpl;
  assign pkt_pad      = desc.pad;
  assign pkt_frag     = desc.frag;
  assign pkt_blocks   = desc.blocks;

endmodule

// File: rtl/txdb_ingress_chk.sv
module txdb_ingress_chk #(
  parameter int CNT_W = 4,
  parameter int NBUF  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] in_cnt,
  input logic [CNT_W-1:0] stat_out_cnt,
  input logic             ovf_ev,
  input logic             ovf_err,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             pkt_buf,
  input logic [7:0]       pkt_id,
  input logic             pkt_done,
  input logic             taken
);

  logic [CNT_W-1:0] occ_w;
  assign occ_w = in_cnt - stat_out_cnt;

  // R2: occupancy never exceeds the buffer count
  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_w) <= NBUF);

  // R3: refused doorbell holds in-count and pulses the error
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (ovf_err && $stable(in_cnt)));

  // R5: offer is held while the consumer stalls
  assert_offer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_buf) && $stable(pkt_id)));

  // R6: release without an accepted buffer is ignored
  assert_stray_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !taken) |=> $stable(stat_out_cnt));

  // R9: out-count only steps by one, wrapping modulo 16
  assert_out_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_out_cnt) |-> (stat_out_cnt == $past(stat_out_cnt) + 1'b1));

endmodule

bind txdb_ingress txdb_ingress_chk #(.CNT_W(CNT_W), .NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .stat_out_cnt(stat_out_cnt),
  .ovf_ev(ovf_ev), .ovf_err(ovf_err), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_buf(pkt_buf[0]), .pkt_id(pkt_id), .pkt_done(pkt_done), .taken(taken)
);

// File: tb/txdb_ingress_bench.sv
module txdb_ingress_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [3:0]  hw_addr = '0;
  logic [31:0] hw_data = '0;
  logic        db = 1'b0;
  logic [3:0]  stat_out_cnt;
  logic        ovf_err, pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [0:0]  pkt_buf;
  logic [15:0] pkt_len, pkt_rate, pkt_frag;
  logic [31:0] pkt_expiry, rd_data;
  logic [7:0]  pkt_queue, pkt_id, pkt_blocks;
  logic [2:0]  pkt_policy;
  logic [1:0]  pkt_type;
  logic        pkt_noack, pkt_qos, pkt_cmpl, pkt_pad;
  logic [3:0]  rd_addr = '0;
  logic        pkt_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdb_ingress u_txdb_ingress (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data), .db(db),
    .stat_out_cnt(stat_out_cnt), .ovf_err(ovf_err), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_buf(pkt_buf), .pkt_len(pkt_len), .pkt_rate(pkt_rate), .pkt_expiry(pkt_expiry),
    .pkt_queue(pkt_queue), .pkt_id(pkt_id), .pkt_policy(pkt_policy), .pkt_noack(pkt_noack),
    .pkt_type(pkt_type), .pkt_qos(pkt_qos), .pkt_cmpl(pkt_cmpl), .pkt_pad(pkt_pad),
    .pkt_frag(pkt_frag), .pkt_blocks(pkt_blocks), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_done(pkt_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] up4(input logic [15:0] l);
    logic [16:0] s;
    s = {1'b0, l} + ((17'd4 - {15'd0, l[1:0]}) % 17'd4);
    return s[15:0];
  endfunction

  task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic ring();
    @(negedge clk); db = 1'b1;
    @(negedge clk); db = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); pkt_ready = 1'b1;
    @(negedge clk); pkt_ready = 1'b0;
  endtask

  task automatic release_buf();
    @(negedge clk); pkt_done = 1'b1;
    @(negedge clk); pkt_done = 1'b0;
  endtask

  task automatic put_desc(input logic [15:0] len, input logic [15:0] rate, input logic [31:0] exp_t,
                          input logic [7:0] q, input logic [7:0] id, input logic [15:0] ctl,
                          input logic [15:0] frag, input logic [7:0] blk);
    host_wr(4'd0, {rate, len});
    host_wr(4'd1, exp_t);
    host_wr(4'd2, {ctl, id, q});
    host_wr(4'd3, {8'h00, blk, frag});
  endtask

  task automatic t_reset();
    check("R1 out count", 32'(stat_out_cnt), 0);
    check("R1 valid", 32'(pkt_valid), 0);
    check("R1 ovf", 32'(ovf_err), 0);
  endtask

  task automatic t_decode();
    // ctl: policy 5, noack 1, type 2, qos 0, cmpl 1, pad 1
    put_desc(16'h003D, 16'h0040, 32'h0001_2345, 8'd3, 8'hA1, 16'h01AD, 16'h0600, 8'd9);
    ring();
    check("R2 valid after doorbell", 32'(pkt_valid), 1);
    check("R1 first buffer", 32'(pkt_buf), 0);
    check("R8 len 0x3D", 32'(pkt_len), 32'(up4(16'h003D)));
    check("R7 rate", 32'(pkt_rate), 32'h40);
    check("R7 expiry", pkt_expiry, 32'h0001_2345);
    check("R7 queue", 32'(pkt_queue), 3);
    check("R7 id", 32'(pkt_id), 32'hA1);
    check("R7 policy", 32'(pkt_policy), 5);
    check("R7 noack", 32'(pkt_noack), 1);
    check("R7 type", 32'(pkt_type), 2);
    check("R7 qos", 32'(pkt_qos), 0);
    check("R7 cmpl", 32'(pkt_cmpl), 1);
    check("R7 pad", 32'(pkt_pad), 1);
    check("R7 frag", 32'(pkt_frag), 32'h600);
    check("R7 blocks", 32'(pkt_blocks), 9);
    rd_addr = 4'd1; #1;
    check("R10 read word1", rd_data, 32'h0001_2345);
  endtask

  task automatic t_second();
    // ctl: qos only, type 1
    put_desc(16'd7, 16'h1000, 32'd50, 8'd1, 8'hB2, 16'h0050, 16'd256, 8'd2);
    ring();
    check("R5 head stays buffer 0", 32'(pkt_buf), 0);
    check("R5 head id", 32'(pkt_id), 32'hA1);
    check("R6 out count", 32'(stat_out_cnt), 0);
  endtask

  task automatic t_overflow();
    ring();
    check("R3 ovf pulse", 32'(ovf_err), 1);
    @(negedge clk);
    check("R3 ovf one cycle", 32'(ovf_err), 0);
  endtask

  task automatic t_ignored_write();
    host_wr(4'd0, 32'hDEAD_BEEF);
    rd_addr = 4'd0; #1;
    check("R4 word0 intact", rd_data, {16'h0040, 16'h003D});
    check("R4 len intact", 32'(pkt_len), 32'h40);
  endtask

  task automatic t_hold();
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R5 valid held", 32'(pkt_valid), 1);
    check("R5 buf held", 32'(pkt_buf), 0);
    release_buf();
    check("R6 stray done ignored", 32'(stat_out_cnt), 0);
    check("R6 still offered", 32'(pkt_valid), 1);
  endtask

  task automatic t_drain();
    accept();
    check("R5 valid drops after accept", 32'(pkt_valid), 0);
    release_buf();
    check("R6 out count 1", 32'(stat_out_cnt), 1);
    check("R2 second buffer", 32'(pkt_buf), 1);
    check("R7 second id", 32'(pkt_id), 32'hB2);
    check("R8 len 7", 32'(pkt_len), 32'(up4(16'd7)));
    check("R7 second type", 32'(pkt_type), 1);
    check("R7 second qos", 32'(pkt_qos), 1);
    accept();
    release_buf();
    check("R6 out count 2", 32'(stat_out_cnt), 2);
    check("R3 refused doorbell not counted", 32'(pkt_valid), 0);
    exp_out = 2;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 18; i++) begin
      logic [15:0] l;
      l = (i == 5) ? 16'hFFFE : ((i == 6) ? 16'd4 : 16'(i * 13 + 1));
      host_wr(4'd0, {16'h0001, l});
      host_wr(4'd2, {16'h0000, 8'(i), 8'd0});
      ring();
      check("R2 alternate buffer", 32'(pkt_buf), 32'(exp_out % 2));
      check("R8 rounded len", 32'(pkt_len), 32'(up4(l)));
      check("R7 loop id", 32'(pkt_id), 32'(i));
      accept();
      release_buf();
      exp_out = (exp_out + 1) % 16;
      check("R9 out count wrap", 32'(stat_out_cnt), 32'(exp_out));
    end
    check("R9 idle after wrap", 32'(pkt_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_second();
    t_overflow();
    t_ignored_write();
    t_hold();
    t_drain();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule